// File: doc/BRIEF.md
# Packed SIMD Arithmetic Logic Unit

This unit combines a 64-bit destination operand with a 64-bit source operand. Both are treated as a row of equal lanes: eight bytes, four words, two doublewords or one quadword. It supports the following operations:

- addition and subtraction, either wrapping or saturating as signed or unsigned values;
- lane-wise equality and signed greater-than compares, which return all-ones or all-zeros masks;
- bitwise logic on the full 64 bits;
- logical and arithmetic lane shifts.

The caller presents one operation per cycle with `in_valid`. The result appears in a register one clock later, and the caller writes it back as the new destination.

For shifts, the count comes from one of two places. It is either the full 64-bit source value or an 8-bit immediate, chosen by `use_imm`. Not every operation exists at every lane size. A request for a missing combination, or for the unused operation code, returns the destination unchanged.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high. It is low one clock after a cycle with `in_valid` low, and `result` then holds its previous value. During reset both outputs are zero.
- R2: Op 0 (add) and op 3 (subtract) wrap modulo the lane width. They are valid at lane_sz 0 (byte), 1 (word) and 2 (doubleword).
- R3: Op 1 (signed saturating add) and op 4 (signed saturating subtract) clamp each lane to the most positive value (0x7F.., sign bit clear) or the most negative value (0x80..). They are valid at byte and word lanes only.
- R4: Op 2 (unsigned saturating add) clamps each lane to all ones. Op 5 (unsigned saturating subtract) clamps each lane to zero. Both are valid at byte and word lanes only.
- R5: Op 6 sets each lane to all ones where dst equals src and to zero elsewhere. It is valid at byte, word and doubleword lanes.
- R6: Op 7 sets each lane to all ones where dst is greater than src as signed two's complement, and to zero elsewhere. It is valid at byte, word and doubleword lanes.
- R7: Ops 8, 9, 10 and 11 give dst AND src, (NOT dst) AND src, dst OR src and dst XOR src on all 64 bits. For these ops lane_sz has no effect.
- R8: Op 12 (shift left logical) and op 13 (shift right logical) are valid at word, doubleword and quadword lanes. A count equal to or above the lane width gives zero.
- R9: Op 14 (shift right arithmetic) is valid at word and doubleword lanes. A count equal to or above the lane width fills the lane with its sign bit, and a word shifted by 15 becomes 0 or all ones.
- R10: With `use_imm` high the shift count is `imm` zero-extended. With `use_imm` low it is the whole 64-bit `src`, so any set bit in src[63:6] makes the shift oversized.
- R11: Unsupported combinations return dst unchanged: op 15, and any valid op at a lane size it lacks (wrap and compare ops at quadword, saturating ops at doubleword or quadword, logical shifts at byte, arithmetic shift at byte or quadword).
- R12: `use_imm` and `imm` have no effect on ops 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code (0..14, 15 unused) |
| lane_sz | input | 2 | Lane size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| dst | input | 64 | Destination operand |
| src | input | 64 | Source operand, or shift count when use_imm is low |
| imm | input | 8 | Immediate shift count |
| use_imm | input | 1 | Take the shift count from imm |
| out_valid | output | 1 | Result register was loaded on the last clock |
| result | output | 64 | Registered result |

## Verification
The assertions take the control inputs `op`, `lane_sz` and `use_imm` to be known, non-X values at every clock edge. They take the operands to be known whenever `in_valid` is high. Their implications about saturation ceilings, self-compares and oversized register counts rely on this.

The stimulus keeps within these limits. It drives every input to a defined value on every cycle, idle cycles included. It draws operands from a pool that mixes boundary patterns (zero, all ones, per-lane sign patterns) with random words. Shift counts cover three cases: small counts, counts near the lane widths, and register counts with upper bits set. Every op code is driven at every lane size, so the legal combinations and the pass-through combinations are both covered.

// File: rtl/simd_alu.sv
module simd_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op,
  input  logic [1:0]  lane_sz,
  input  logic [63:0] dst,
  input  logic [63:0] src,
  input  logic [7:0]  imm,
  input  logic        use_imm,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDS  = 4'd1;
  localparam logic [3:0] OP_ADDUS = 4'd2;
  localparam logic [3:0] OP_SUB   = 4'd3;
  localparam logic [3:0] OP_SUBS  = 4'd4;
  localparam logic [3:0] OP_SUBUS = 4'd5;
  localparam logic [3:0] OP_CMPEQ = 4'd6;
  localparam logic [3:0] OP_CMPGT = 4'd7;
  localparam logic [3:0] OP_AND   = 4'd8;
  localparam logic [3:0] OP_ANDN  = 4'd9;
  localparam logic [3:0] OP_OR    = 4'd10;
  localparam logic [3:0] OP_XOR   = 4'd11;
  localparam logic [3:0] OP_SLL   = 4'd12;
  localparam logic [3:0] OP_SRL   = 4'd13;
  localparam logic [3:0] OP_SRA   = 4'd14;

  wire [63:0] cnt = use_imm ? {56'd0, imm} : src;

  wire wrap_ok = lane_sz != 2'd3;
  wire sat_ok  = !lane_sz[1];
  wire shl_ok  = lane_sz != 2'd0;
  wire sra_ok  = (lane_sz == 2'd1) || (lane_sz == 2'd2);

  logic [3:0][63:0] by_size;
  logic [63:0]      nxt;

  genvar k, l;
  generate
    for (k = 0; k < 4; k++) begin : g_sz
      localparam int LW = 8 << k;
      localparam int NL = 64 / LW;
      wire big = cnt >= 64'(LW);
      for (l = 0; l < NL; l++) begin : g_ln
        wire [LW-1:0] a    = dst[l*LW +: LW];
        wire [LW-1:0] b    = src[l*LW +: LW];
        wire [LW:0]   uadd = {1'b0, a} + {1'b0, b};
        wire [LW:0]   usub = {1'b0, a} - {1'b0, b};
        wire [LW:0]   sadd = {a[LW-1], a} + {b[LW-1], b};
        wire [LW:0]   ssub = {a[LW-1], a} - {b[LW-1], b};
        wire [LW-1:0] smax = {1'b0, {(LW-1){1'b1}}};
        wire [LW-1:0] smin = ~smax;
        logic [LW-1:0] r;
        always_comb begin
          case (op)
            OP_ADD:   r = uadd[LW-1:0];
            OP_SUB:   r = usub[LW-1:0];
            OP_ADDS:  r = (sadd[LW] != sadd[LW-1]) ? (sadd[LW] ? smin : smax) : sadd[LW-1:0];
            OP_SUBS:  r = (ssub[LW] != ssub[LW-1]) ? (ssub[LW] ? smin : smax) : ssub[LW-1:0];
            OP_ADDUS: r = uadd[LW] ? {LW{1'b1}} : uadd[LW-1:0];
            OP_SUBUS: r = usub[LW] ? {LW{1'b0}} : usub[LW-1:0];
            OP_CMPEQ: r = {LW{a == b}};
            OP_CMPGT: r = {LW{$signed(a) > $signed(b)}};
            OP_SLL:   r = big ? {LW{1'b0}} : a << cnt[5:0];
            OP_SRL:   r = big ? {LW{1'b0}} : a >> cnt[5:0];
            OP_SRA:   r = big ? {LW{a[LW-1]}} : LW'($signed(a) >>> cnt[5:0]);
            default:  r = a;
          endcase
        end
        assign by_size[k][l*LW +: LW] = r;
      end
    end
  endgenerate

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_CMPEQ, OP_CMPGT:
        nxt = wrap_ok ? by_size[lane_sz] : dst;
      OP_ADDS, OP_SUBS, OP_ADDUS, OP_SUBUS:
        nxt = sat_ok ? by_size[lane_sz] : dst;
      OP_AND:  nxt = dst & src;
      OP_ANDN: nxt = ~dst & src;
      OP_OR:   nxt = dst | src;
      OP_XOR:  nxt = dst ^ src;
      OP_SLL, OP_SRL:
        nxt = shl_ok ? by_size[lane_sz] : dst;
      OP_SRA:
        nxt = sra_ok ? by_size[lane_sz] : dst;
      default: nxt = dst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd15 || ((op == OP_ADDS || op == OP_SUBUS) && lane_sz[1])))
      |=> result == $past(dst));
  assert_self_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMPEQ && lane_sz != 2'd3 && dst == src) |=> result == '1);
  assert_self_greater_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMPGT && lane_sz != 2'd3 && dst == src) |=> result == '0);
  assert_uadd_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADDUS && !lane_sz[1] && src == '1) |=> result == '1);
  assert_usub_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SUBUS && !lane_sz[1] && dst == src) |=> result == '0);
  assert_wide_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_SLL || op == OP_SRL) && lane_sz != 2'd0 && !use_imm && src[63:32] != '0)
      |=> result == '0);
endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic [63:0] dst = '0;
  logic [63:0] src = '0;
  logic [7:0]  imm = '0;
  logic        use_imm = 1'b0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [63:0] exp_res = '0;

  always #10 clk = ~clk;

  simd_alu i_simd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .dst(dst), .src(src), .imm(imm), .use_imm(use_imm),
    .out_valid(out_valid), .result(result)
  );

  function automatic bit legal(input logic [3:0] o, input logic [1:0] z);
    if (o == 15) return 0;
    if ((o == 0 || o == 3 || o == 6 || o == 7) && z == 3) return 0;
    if ((o == 1 || o == 2 || o == 4 || o == 5) && z > 1) return 0;
    if ((o == 12 || o == 13) && z == 0) return 0;
    if (o == 14 && (z == 0 || z == 3)) return 0;
    return 1;
  endfunction

  function automatic string req_of(input logic [3:0] o, input logic [1:0] z, input logic ui);
    if (!legal(o, z)) return "R11";
    case (o)
      0, 3: return "R2";
      1, 4: return "R3";
      2, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9, 10, 11: return ui ? "R12" : "R7";
      12, 13: return ui ? "R10" : "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] z,
                                        input logic [63:0] d, input logic [63:0] s,
                                        input logic [7:0] im, input logic ui);
    int w, n;
    logic [63:0] m, cnt, res, a, b, r;
    longint sa, sb, t, lo, hi;
    w = 8 << z;
    n = 64 / w;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    cnt = ui ? {56'd0, im} : s;
    case (o)
      8:  return d & s;
      9:  return ~d & s;
      10: return d | s;
      11: return d ^ s;
      default: ;
    endcase
    if (!legal(o, z)) return d;
    res = '0;
    for (int i = 0; i < n; i++) begin
      a = (d >> (i * w)) & m;
      b = (s >> (i * w)) & m;
      sa = (w < 64 && a[w-1]) ? longint'(a) - (longint'(1) << w) : longint'(a);
      sb = (w < 64 && b[w-1]) ? longint'(b) - (longint'(1) << w) : longint'(b);
      hi = (longint'(1) << (w - 1)) - 1;
      lo = -hi - 1;
      r = '0;
      case (o)
        0: r = a + b;
        3: r = a - b;
        1, 4: begin
          t = (o == 1) ? sa + sb : sa - sb;
          if (t > hi) t = hi;
          if (t < lo) t = lo;
          r = 64'(t);
        end
        2: r = (a + b > m) ? m : a + b;
        5: r = (a < b) ? 64'd0 : a - b;
        6: r = (a == b) ? m : 64'd0;
        7: r = (sa > sb) ? m : 64'd0;
        12: r = (cnt >= 64'(w)) ? 64'd0 : (a << cnt);
        13: r = (cnt >= 64'(w)) ? 64'd0 : (a >> cnt);
        default: r = (cnt >= 64'(w)) ? (a[w-1] ? m : 64'd0) : 64'(sa >>> cnt[5:0]);
      endcase
      res |= (r & m) << (i * w);
    end
    return res;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic [1:0] z,
                      input logic [63:0] d, input logic [63:0] s,
                      input logic [7:0] im, input logic ui, input string tag);
    string req;
    req = (tag != "") ? tag : (v ? req_of(o, z, ui) : "R1");
    @(negedge clk);
    in_valid = v; op = o; lane_sz = z; dst = d; src = s; imm = im; use_imm = ui;
    if (v) exp_res = model(o, z, d, s, im, ui);
    @(posedge clk);
    @(negedge clk);
    check(req, "out_valid", {63'd0, out_valid}, {63'd0, v});
    check(req, "result", result, exp_res);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return '0;
      1: return '1;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h7F7F_7F7F_7F7F_7F7F;
      4: return 64'h8000_7FFF_0001_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "reset result", result, 64'd0);
    rst_n = 1'b1;

    step(1, 0, 0, 64'hFF01_FF01_FF01_FF01, 64'h0101_0101_0101_0101, 0, 0, "R2");
    step(1, 3, 2, 64'h0000_0000_0000_0001, 64'h0000_0002_0000_0002, 0, 0, "R2");
    step(1, 1, 1, 64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_8000_0001, 0, 0, "R3");
    step(1, 4, 0, 64'h8080_7F7F_0000_8000, 64'h0101_FFFF_8080_0080, 0, 0, "R3");
    step(1, 2, 0, 64'hF0F0_0102_FF00_0000, 64'h2020_0304_0100_0000, 0, 0, "R4");
    step(1, 5, 1, 64'h0001_0005_FFFF_0000, 64'h0002_0003_FFFF_0001, 0, 0, "R4");
    step(1, 6, 1, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, 0, 0, "R5");
    step(1, 7, 0, 64'h01FF_7F80_0000_0102, 64'hFF01_807F_0000_0201, 0, 0, "R6");
    step(1, 7, 2, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0004, 0, 0, "R6");
    step(1, 9, 3, 64'hF0F0_0000_FFFF_1234, 64'hFFFF_FFFF_0F0F_FFFF, 0, 0, "R7");
    step(1, 14, 1, 64'h8000_7FFF_FFFF_0001, 64'd0, 8'd15, 1, "R9");
    step(1, 14, 2, 64'h8000_0000_7FFF_FFFF, 64'd40, 0, 0, "R9");
    step(1, 12, 2, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 0, 0, "R10");
    step(1, 13, 3, 64'h8000_0000_0000_0000, 64'd0, 8'd63, 1, "R8");
    step(1, 13, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd64, 1, "R8");
    step(1, 12, 1, 64'h1234_1234_1234_1234, 64'd0, 8'd16, 1, "R8");
    step(1, 1, 2, 64'hDEAD_BEEF_0000_1111, 64'h1111_1111_1111_1111, 0, 0, "R11");
    step(1, 15, 0, 64'hCAFE_F00D_1234_5678, 64'hFFFF, 0, 0, "R11");
    step(1, 12, 0, 64'h0102_0304_0506_0708, 64'd1, 0, 0, "R11");
    step(1, 0, 1, 64'h0001_0002_0003_0004, 64'h0001_0001_0001_0001, 8'hFF, 1, "R12");
    step(0, 0, 0, 64'h5555, 64'h5555, 0, 0, "R1");
    step(0, 3, 1, 64'h1, 64'h2, 0, 0, "R1");

    for (int i = 0; i < 6000; i++) begin
      logic [3:0] o;
      logic [1:0] z;
      logic [63:0] d, s;
      logic [7:0] im;
      logic ui, v;
      o = 4'($urandom);
      z = 2'($urandom);
      d = pick();
      s = pick();
      if (($urandom % 3) == 0) s = d;
      im = 8'($urandom);
      if (($urandom % 2) == 0) im = 8'($urandom % 70);
      ui = 1'($urandom);
      if (o >= 12 && !ui && ($urandom % 2) == 0) s = 64'($urandom % 70);
      v = ($urandom % 10) != 0;
      step(v, o, z, d, s, im, ui, "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule